// File: doc/BRIEF.md
# Boundary-Scanned Dual-Byte Inverting Line Driver

Two independent 9-bit byte lanes, A and B, each drive the bitwise inverse of their data inputs. Each lane has a pair of active-low enable pins. When both are low, the lane drives all nine bits. When either is high, the whole lane is released, modelled here as a cleared per-bit drive flag next to the data vector.

A 42-cell boundary-scan register wraps every pin. Input pins (data and enables) carry observe-only cells. The outputs and the two internal active-high lane enables carry control-capable cells, which add an update latch. The test-access controller is external and supplies decoded strobes: capture, shift, update, a mode select that hands outputs and enables to the update latches (clamp), and a force-off that releases every output (high-Z). Scan cells move on the rising edge of the test clock. Update latches load on the falling edge.

Top module: `bscan_inv_driver`

## Requirements
- R1: With mode_i=0 and force_off_i=0, a_data_o equals ~a_data_i and b_data_o equals ~b_data_i, bit for bit.
- R2: With mode_i=0 and force_off_i=0, a lane's nine drive bits are all 1 when both of its enable pins are 0, and all 0 for each of the other three enable combinations.
- R3: One lane's enable pins have no effect on the other lane's drive or data outputs.
- R4: A rising edge with capture_i=1 loads the chain. Chain index k counts from the serial input end. The loaded values are: 0..8 = a_data_i[0..8]; 9..10 = a_oe_n_i[0..1]; 11..19 = b_data_i[0..8]; 20..21 = b_oe_n_i[0..1]; 22 = the lane A internal enable (1 when both A enable pins are 0); 23 = the lane B internal enable; 24..32 = ~a_data_i[0..8]; 33..41 = ~b_data_i[0..8].
- R5: A rising edge with shift_i=1 and capture_i=0 moves each cell one step toward index 41, with scan_in_i entering index 0. scan_out_o shows index 41, so a bit presented on scan_in_i reaches scan_out_o after 42 shift edges.
- R6: On a falling edge with update_i=1, the update latches copy chain indices 22..41. Otherwise the latches hold, even while the chain shifts.
- R7: With mode_i=1 and force_off_i=0, a_data_o is taken from latch indices 24..32 and b_data_o from 33..41. Every A drive bit equals latch 22 and every B drive bit equals latch 23.
- R8: With force_off_i=1, all 18 drive bits are 0 whatever mode_i, the enable pins and the latches hold.
- R9: When rst_ni=0, all chain cells and update latches are cleared, so scan_out_o is 0 and, in clamp mode, outputs are 0 and undriven.
- R10: Capture takes priority over shift. With both strobes low, the chain holds and scan_out_o stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset of scan state |
| a_data_i | input | 9 | Lane A data inputs |
| a_oe_n_i | input | 2 | Lane A active-low enable pins |
| b_data_i | input | 9 | Lane B data inputs |
| b_oe_n_i | input | 2 | Lane B active-low enable pins |
| a_data_o | output | 9 | Lane A output values |
| a_drive_o | output | 9 | Lane A per-bit drive flags (0 = high-Z) |
| b_data_o | output | 9 | Lane B output values |
| b_drive_o | output | 9 | Lane B per-bit drive flags (0 = high-Z) |
| scan_in_i | input | 1 | Serial scan data in |
| scan_out_o | output | 1 | Serial scan data out (chain index 41) |
| capture_i | input | 1 | Parallel-load strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update latch strobe (falling edge) |
| mode_i | input | 1 | 1 = outputs and enables from update latches |
| force_off_i | input | 1 | 1 = all outputs released |

## Verification
The lane outputs are combinational in the pins, mode_i and force_off_i, so their results are due in the same cycle. The bench drives these inputs 3 ns after a rising edge and checks half a nanosecond later. Chain results are due one rising edge after a capture or shift strobe. Latch results are due at the falling edge that follows an update strobe. The bench therefore does all its driving and sampling 3 ns after each rising edge, which is past the mid-period falling edge and well clear of the next rising edge. The serial pattern test reads scan_out_o after every shift edge and expects the first bit back after exactly 42 of them.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;
  localparam int unsigned LANE_W  = 9;
  localparam int unsigned OE_PINS = 2;
  localparam int unsigned LANES   = 2;
endpackage

// File: rtl/bscan_obs_seg.sv
`timescale 1ns/1ps
// Observe-only scan cells: capture and shift, no update stage.
module bscan_obs_seg #(
  parameter int unsigned W = 22
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         si_i,
  input  logic [W-1:0] cap_i,
  output logic         so_o
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stage_q <= '0;
    else if (capture_i) stage_q <= cap_i;
    else if (shift_i)   stage_q <= {stage_q[W-2:0], si_i};
  end

  assign so_o = stage_q[W-1];
endmodule

// File: rtl/bscan_ctl_seg.sv
`timescale 1ns/1ps
// Control-capable scan cells: capture/shift stage plus falling-edge update latch.
module bscan_ctl_seg #(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         update_i,
  input  logic         si_i,
  input  logic [W-1:0] cap_i,
  output logic         so_o,
  output logic [W-1:0] upd_o
);
  logic [W-1:0] stage_q;
  logic [W-1:0] upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stage_q <= '0;
    else if (capture_i) stage_q <= cap_i;
    else if (shift_i)   stage_q <= {stage_q[W-2:0], si_i};
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       upd_q <= '0;
    else if (update_i) upd_q <= stage_q;
  end

  assign so_o  = stage_q[W-1];
  assign upd_o = upd_q;
endmodule

// File: rtl/bscan_lane.sv
`timescale 1ns/1ps
// One lane: enable combine, inversion, scan override and force-off.
module bscan_lane #(
  parameter int unsigned W   = 9,
  parameter int unsigned OEN = 2
) (
  input  logic [W-1:0]   data_i,
  input  logic [OEN-1:0] oe_n_i,
  input  logic           upd_en_i,
  input  logic [W-1:0]   upd_data_i,
  input  logic           mode_i,
  input  logic           force_off_i,
  output logic           sys_en_o,
  output logic [W-1:0]   sys_data_o,
  output logic [W-1:0]   data_o,
  output logic [W-1:0]   drive_o
);
  logic en_sel;

  assign sys_en_o   = ~|oe_n_i;
  assign sys_data_o = ~data_i;
  assign en_sel     = mode_i ? upd_en_i : sys_en_o;
  assign data_o     = mode_i ? upd_data_i : sys_data_o;
  assign drive_o    = (force_off_i || !en_sel) ? '0 : '1;
endmodule

// File: rtl/bscan_inv_driver.sv
`timescale 1ns/1ps
module bscan_inv_driver
  import bscan_pkg::*;
#(
  parameter int unsigned BYTE_W = LANE_W,
  parameter int unsigned OE_N   = OE_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] a_data_i,
  input  logic [OE_N-1:0]   a_oe_n_i,
  input  logic [BYTE_W-1:0] b_data_i,
  input  logic [OE_N-1:0]   b_oe_n_i,
  output logic [BYTE_W-1:0] a_data_o,
  output logic [BYTE_W-1:0] a_drive_o,
  output logic [BYTE_W-1:0] b_data_o,
  output logic [BYTE_W-1:0] b_drive_o,
  input  logic              scan_in_i,
  output logic              scan_out_o,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              mode_i,
  input  logic              force_off_i
);
  localparam int unsigned NB    = LANES;
  localparam int unsigned OBS_W = NB * (BYTE_W + OE_N);
  localparam int unsigned CTL_W = NB + NB * BYTE_W;

  logic [NB-1:0][BYTE_W-1:0] din, sys_dout, upd_dout, dout, drv;
  logic [NB-1:0][OE_N-1:0]   oe_n;
  logic [NB-1:0]             sys_en, upd_en;
  logic [CTL_W-1:0]          ctl_upd;
  logic                      mid_so;

  assign din[0]  = a_data_i;
  assign din[1]  = b_data_i;
  assign oe_n[0] = a_oe_n_i;
  assign oe_n[1] = b_oe_n_i;

  // Chain order from serial input: pins (A, then B), internal enables, outputs.
  bscan_obs_seg #(.W(OBS_W)) u_obs (
    .clk_i, .rst_ni, .capture_i, .shift_i,
    .si_i  (scan_in_i),
    .cap_i ({oe_n[1], din[1], oe_n[0], din[0]}),
    .so_o  (mid_so)
  );

  bscan_ctl_seg #(.W(CTL_W)) u_ctl (
    .clk_i, .rst_ni, .capture_i, .shift_i, .update_i,
    .si_i  (mid_so),
    .cap_i ({sys_dout, sys_en}),
    .so_o  (scan_out_o),
    .upd_o (ctl_upd)
  );

  assign upd_en = ctl_upd[NB-1:0];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign upd_dout[g] = ctl_upd[NB + g*BYTE_W +: BYTE_W];

    bscan_lane #(.W(BYTE_W), .OEN(OE_N)) u_lane (
      .data_i      (din[g]),
      .oe_n_i      (oe_n[g]),
      .upd_en_i    (upd_en[g]),
      .upd_data_i  (upd_dout[g]),
      .mode_i      (mode_i),
      .force_off_i (force_off_i),
      .sys_en_o    (sys_en[g]),
      .sys_data_o  (sys_dout[g]),
      .data_o      (dout[g]),
      .drive_o     (drv[g])
    );
  end

  assign a_data_o  = dout[0];
  assign b_data_o  = dout[1];
  assign a_drive_o = drv[0];
  assign b_drive_o = drv[1];
endmodule

// File: rtl/bscan_inv_driver_chk.sv
`timescale 1ns/1ps
module bscan_inv_driver_chk #(
  parameter int unsigned BYTE_W = 9,
  parameter int unsigned OE_N   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] a_data_i,
  input logic [OE_N-1:0]   a_oe_n_i,
  input logic [BYTE_W-1:0] b_data_i,
  input logic [OE_N-1:0]   b_oe_n_i,
  input logic [BYTE_W-1:0] a_data_o,
  input logic [BYTE_W-1:0] a_drive_o,
  input logic [BYTE_W-1:0] b_data_o,
  input logic [BYTE_W-1:0] b_drive_o,
  input logic              scan_in_i,
  input logic              scan_out_o,
  input logic              capture_i,
  input logic              shift_i,
  input logic              update_i,
  input logic              mode_i,
  input logic              force_off_i
);
  p_invert_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !force_off_i) |-> (a_data_o == ~a_data_i && b_data_o == ~b_data_i));

  p_lane_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !force_off_i && a_oe_n_i != '0) |-> (a_drive_o == '0));

  p_lane_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !force_off_i && b_oe_n_i == '0) |-> (&b_drive_o));

  p_drive_uniform_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_drive_o == '0 || &a_drive_o) && (b_drive_o == '0 || &b_drive_o)));

  p_force_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |-> (a_drive_o == '0 && b_drive_o == '0));

  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (scan_out_o == !$past(b_data_i[BYTE_W-1])));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i && !shift_i) |=> $stable(scan_out_o));

  p_latch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $past(mode_i) && !update_i) |-> ($stable(a_data_o) && $stable(b_data_o)));
endmodule

bind bscan_inv_driver bscan_inv_driver_chk #(.BYTE_W(BYTE_W), .OE_N(OE_N)) u_chk (.*);

// File: tb/tb_bscan_inv_driver.sv
`timescale 1ns/1ps
module tb_bscan_inv_driver;
  localparam int unsigned W = 9;
  localparam int unsigned CHAIN = 42;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] a_data_i = '0, b_data_i = '0;
  logic [1:0] a_oe_n_i = '0, b_oe_n_i = '0;
  logic [W-1:0] a_data_o, a_drive_o, b_data_o, b_drive_o;
  logic scan_in_i = 1'b0, scan_out_o;
  logic capture_i = 1'b0, shift_i = 1'b0, update_i = 1'b0;
  logic mode_i = 1'b0, force_off_i = 1'b0;

  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  bscan_inv_driver dut (.*);

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Advance to 3 ns after the next rising edge (past the falling edge).
  task automatic step();
    @(posedge clk_i); #3;
  endtask

  task automatic settle();
    #0.5;
  endtask

  function automatic logic [CHAIN-1:0] exp_cap(input logic [W-1:0] a, input logic [1:0] ao,
                                                input logic [W-1:0] b, input logic [1:0] bo);
    return {~b, ~a, ~|bo, ~|ao, bo, b, ao, a};
  endfunction

  task automatic load_chain(input logic [CHAIN-1:0] v);
    shift_i = 1'b1;
    for (int k = CHAIN-1; k >= 0; k--) begin
      scan_in_i = v[k];
      step();
    end
    shift_i = 1'b0;
    scan_in_i = 1'b0;
  endtask

  task automatic t_reset();
    mode_i = 1'b1; settle();
    check(scan_out_o == 1'b0, "R9 scan_out", 64'(scan_out_o), 64'd0);
    check(a_data_o == '0 && b_data_o == '0, "R9 latch data", 64'({a_data_o, b_data_o}), 64'd0);
    check(a_drive_o == '0 && b_drive_o == '0, "R9 latch drive", 64'({a_drive_o, b_drive_o}), 64'd0);
    mode_i = 1'b0; settle();
  endtask

  task automatic t_normal();
    logic [W-1:0] pats [4] = '{9'h000, 9'h1ff, 9'h155, 9'h0a3};
    a_oe_n_i = '0; b_oe_n_i = '0;
    for (int i = 0; i < 4; i++) begin
      a_data_i = pats[i]; b_data_i = pats[(i+1)%4]; settle();
      check(a_data_o == ~pats[i], "R1 lane A", 64'(a_data_o), 64'(~pats[i]));
      check(b_data_o == ~pats[(i+1)%4], "R1 lane B", 64'(b_data_o), 64'(~pats[(i+1)%4]));
    end
  endtask

  task automatic t_enables();
    for (int ea = 0; ea < 4; ea++) begin
      for (int eb = 0; eb < 4; eb++) begin
        logic [W-1:0] xa, xb;
        a_oe_n_i = 2'(ea); b_oe_n_i = 2'(eb); settle();
        xa = (ea == 0) ? '1 : '0;
        xb = (eb == 0) ? '1 : '0;
        check(a_drive_o == xa, "R2 lane A drive", 64'(a_drive_o), 64'(xa));
        check(b_drive_o == xb, "R3 lane B independent", 64'(b_drive_o), 64'(xb));
        check(b_data_o == ~b_data_i, "R3 lane B data", 64'(b_data_o), 64'(~b_data_i));
      end
    end
    a_oe_n_i = '0; b_oe_n_i = '0;
  endtask

  task automatic t_capture_shift();
    logic [CHAIN-1:0] exp;
    a_data_i = 9'h13c; a_oe_n_i = 2'b10; b_data_i = 9'h0e5; b_oe_n_i = 2'b00;
    exp = exp_cap(a_data_i, a_oe_n_i, b_data_i, b_oe_n_i);
    capture_i = 1'b1; shift_i = 1'b1; step();   // capture wins over shift
    capture_i = 1'b0;
    check(scan_out_o == exp[CHAIN-1], "R10 capture priority", 64'(scan_out_o), 64'(exp[CHAIN-1]));
    shift_i = 1'b0;
    step(); step();
    check(scan_out_o == exp[CHAIN-1], "R10 hold", 64'(scan_out_o), 64'(exp[CHAIN-1]));
    begin
      logic [CHAIN-1:0] got;
      shift_i = 1'b1;
      for (int k = CHAIN-1; k >= 0; k--) begin
        got[k] = scan_out_o;
        step();
      end
      shift_i = 1'b0;
      check(got == exp, "R4 captured vector", 64'(got), 64'(exp));
    end
  endtask

  task automatic t_shift_through();
    logic [CHAIN:0] p = 43'h5a3_c96e_1b2d;
    shift_i = 1'b1;
    for (int s = 0; s < 83; s++) begin
      scan_in_i = (s <= CHAIN) ? p[s] : 1'b0;
      step();
      if (s >= CHAIN-1)
        check(scan_out_o == p[s-(CHAIN-1)], "R5 emerge after 42", 64'(scan_out_o), 64'(p[s-(CHAIN-1)]));
    end
    shift_i = 1'b0; scan_in_i = 1'b0;
  endtask

  task automatic t_update_clamp();
    logic [CHAIN-1:0] v = 42'h2b5_4c3a_9e17;
    logic [W-1:0] va, vb, keep_a, keep_b;
    v[22] = 1'b1; v[23] = 1'b0;
    va = v[32:24]; vb = v[41:33];
    load_chain(v);
    update_i = 1'b1; step(); update_i = 1'b0;
    mode_i = 1'b1; force_off_i = 1'b0; settle();
    check(a_data_o == va, "R7 clamp A data", 64'(a_data_o), 64'(va));
    check(b_data_o == vb, "R7 clamp B data", 64'(b_data_o), 64'(vb));
    check(a_drive_o == '1 && b_drive_o == '0, "R7 clamp drive", 64'({a_drive_o, b_drive_o}), 64'({9'h1ff, 9'h0}));
    keep_a = a_data_o; keep_b = b_data_o;
    a_data_i = ~a_data_i; a_oe_n_i = 2'b11;
    load_chain(~v);
    settle();
    check(a_data_o == keep_a && b_data_o == keep_b, "R6 latch holds", 64'({a_data_o, b_data_o}), 64'({keep_a, keep_b}));
    check(a_drive_o == '1, "R6 enable latch holds", 64'(a_drive_o), 64'h1ff);
    update_i = 1'b1; step(); update_i = 1'b0; settle();
    check(a_data_o == ~va && b_drive_o == '1 && a_drive_o == '0, "R6 new update",
          64'({a_data_o, a_drive_o, b_drive_o}), 64'({~va, 9'h0, 9'h1ff}));
    mode_i = 1'b0; a_oe_n_i = '0; settle();
    check(a_data_o == ~a_data_i, "R1 back to system", 64'(a_data_o), 64'(~a_data_i));
  endtask

  task automatic t_highz();
    a_oe_n_i = '0; b_oe_n_i = '0;
    for (int m = 0; m < 2; m++) begin
      mode_i = m[0]; force_off_i = 1'b1; settle();
      check(a_drive_o == '0 && b_drive_o == '0, "R8 force off", 64'({a_drive_o, b_drive_o}), 64'd0);
    end
    force_off_i = 1'b0; mode_i = 1'b0; settle();
    check(a_drive_o == '1 && b_drive_o == '1, "R8 release", 64'({a_drive_o, b_drive_o}), 64'h3ffff);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", n_chk, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    step(); rst_ni = 1'b1; step();
    t_normal();
    t_enables();
    t_capture_shift();
    t_shift_through();
    t_update_clamp();
    t_highz();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule